// File: doc/BRIEF.md
# External Data Memory Bus Controller

This block carries out single-byte data reads and writes for a small processor core. The core presents an address, a direction and, for writes, a byte, and raises a one-clock start. The block then decodes the address. The lowest 1 KB goes to an on-chip SRAM, and that access takes a single clock. Every higher address goes out over a multiplexed external bus. A one-clock done pulse ends each access, and for reads the byte returned is presented with that pulse.

On the external bus, the low address byte and the data share one port. That port is modelled as an output value, an output enable and an input value. A latch strobe marks the low address, and the high address byte has its own output. Separate active-low strobes mark reads and writes. A 3-bit stretch code, sampled at start, sets the shape of the cycle:
- Code 0 gives the base four-clock cycle.
- Code 1 adds one clock of setup and one clock of hold. The strobe is left unchanged.
- Codes 2 and 3 widen the strobe by whole four-clock machine cycles.
- Codes 4 to 7 count as 7 to 10 stretch machine cycles. Three of these widen the latch pulse, the setup and the hold, and the remainder widen the strobe.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, ale is 0, rd_n and wr_n are 1, ad_oe is 0, sram_en is 0 and done is 0.
- R2: An address with bits 15:10 all zero (0000h to 03FFh) makes one clock with sram_en high, sram_addr = address bits 9:0 and sram_we = write. In that clock the external bus stays idle. Done follows in the next clock. Any address of 0400h or above uses the external bus and never raises sram_en.
- R3: An external access runs four phases in order: latch (ale high), setup, strobe, then hold. Done is high in the clock after the hold phase. With stretch code 0, each phase lasts one clock, giving 4 clocks of bus activity.
- R4: With stretch code 1, latch is 1 clock, setup is 2 clocks, strobe is 1 clock and hold is 2 clocks, a total of 6.
- R5: With stretch codes 2 and 3, latch, setup and hold are 1 clock each, and the strobe lasts 1 + 4×code clocks (9 and 13).
- R6: Stretch codes 4 to 7 stand for S = code + 3 stretch machine cycles. Latch, setup and hold are 5 clocks each, and the strobe lasts 1 + 4×(S − 3) clocks (17, 21, 25 and 29).
- R7: On a read, ad_oe is high only during the latch phase, so the port is never driven while rd_n is low. The byte on ad_in is captured on the clock edge that ends the strobe. It appears on rdata while done is high and stays there until the next access completes.
- R8: On a write, ad_oe is high for the whole access. ad_out carries address bits 7:0 during the latch phase, and the write byte from setup through hold. wr_n is low only during the strobe phase.
- R9: During every clock of an external access, from latch through hold, ad_hi carries address bits 15:8. When no external access is active, ad_hi is 0.
- R10: The stretch code is sampled in the clock where start is accepted. A change to the code later in the access does not alter the cycle shape.
- R11: Start is accepted only when idle. A start raised during any later clock of an access, including the done clock, is ignored. It changes neither the bus activity nor the number of done pulses.
- R12: Done is a single-clock pulse, given exactly once per access. rd_n and wr_n are never low together, and neither is low while ale is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock access request, accepted when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write byte |
| stretch | input | 3 | Stretch code, sampled at start |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read byte, valid with done |
| sram_en | output | 1 | On-chip SRAM access clock |
| sram_we | output | 1 | On-chip SRAM write enable |
| sram_addr | output | 10 | On-chip SRAM address |
| sram_wdata | output | 8 | On-chip SRAM write byte |
| sram_rdata | input | 8 | On-chip SRAM read byte (asynchronous) |
| ad_out | output | 8 | Multiplexed low-address/data value to drive |
| ad_oe | output | 1 | Drive enable for the multiplexed port |
| ad_in | input | 8 | Value sampled from the multiplexed port |
| ad_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
All outputs are decoded from registered state. Call the edge that accepts start edge 0. Clock k after edge 0 then shows phase k of the access: the latch phase begins in clock 1, and done falls in clock T+1, where T is the sum of the four phase lengths. For on-chip accesses, T is 1. The bench drives inputs on falling edges and compares every output on each falling edge against a model. The model takes the phase lengths for each stretch code straight from the requirements. Read data is checked in clock T+1. The model of the external device drives the port only while rd_n is low, so a capture on the wrong edge returns zero.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int LEN_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INT,
        PH_ALE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] ale;
        logic [LEN_W-1:0] setup;
        logic [LEN_W-1:0] strobe;
        logic [LEN_W-1:0] hold;
    } shape_t;

endpackage

// File: rtl/xmem_route.sv
module xmem_route #(
    parameter int AW      = 16,
    parameter int SRAM_AW = 10
) (
    input  logic [AW-1:0]      addr,
    output logic               is_int,
    output logic [SRAM_AW-1:0] local_addr
);
    localparam int HI_W = AW - SRAM_AW;

    always_comb begin
        is_int     = (addr[AW-1:SRAM_AW] == HI_W'(0));
        local_addr = addr[SRAM_AW-1:0];
    end
endmodule

// File: rtl/xmem_stretch_map.sv
module xmem_stretch_map
    import xmem_pkg::*;
#(
    parameter int CPM       = 4,
    parameter int LONG_BIAS = 3
) (
    input  logic [2:0] code,
    output shape_t     shape
);
    int sc;

    always_comb begin
        sc = code[2] ? (int'(code) + LONG_BIAS) : int'(code);
        shape.ale    = LEN_W'(1);
        shape.setup  = LEN_W'(1);
        shape.strobe = LEN_W'(1);
        shape.hold   = LEN_W'(1);
        if (code == 3'd1) begin
            shape.setup = LEN_W'(2);
            shape.hold  = LEN_W'(2);
        end else if (code[2]) begin
            shape.ale    = LEN_W'(1 + CPM);
            shape.setup  = LEN_W'(1 + CPM);
            shape.hold   = LEN_W'(1 + CPM);
            shape.strobe = LEN_W'(1 + CPM * (sc - 3));
        end else if (code != 3'd0) begin
            shape.strobe = LEN_W'(1 + CPM * sc);
        end
    end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int SRAM_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic               start_int,
    input  shape_t             shape_in,
    output logic               done,
    output logic [DW-1:0]      rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DW-1:0]      sram_wdata,
    input  logic [DW-1:0]      sram_rdata,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    input  logic [DW-1:0]      ad_in,
    output logic [AW-DW-1:0]   ad_hi,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);
    localparam int HI_W = AW - DW;

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        shape_t           shape;
        logic             we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
    } seq_t;

    seq_t d, q;
    logic cnt_end;
    logic ext_active;

    always_comb begin
        d       = q;
        cnt_end = (q.cnt == LEN_W'(0));
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.we    = we;
                    d.addr  = addr;
                    d.wdata = wdata;
                    d.shape = shape_in;
                    if (start_int) begin
                        d.phase = PH_INT;
                    end else begin
                        d.phase = PH_ALE;
                        d.cnt   = shape_in.ale - LEN_W'(1);
                    end
                end
            end
            PH_INT: begin
                if (!q.we) d.rdata = sram_rdata;
                d.phase = PH_DONE;
            end
            PH_ALE: begin
                if (cnt_end) begin
                    d.phase = PH_SETUP;
                    d.cnt   = q.shape.setup - LEN_W'(1);
                end else d.cnt = q.cnt - LEN_W'(1);
            end
            PH_SETUP: begin
                if (cnt_end) begin
                    d.phase = PH_STROBE;
                    d.cnt   = q.shape.strobe - LEN_W'(1);
                end else d.cnt = q.cnt - LEN_W'(1);
            end
            PH_STROBE: begin
                if (cnt_end) begin
                    if (!q.we) d.rdata = ad_in;
                    d.phase = PH_HOLD;
                    d.cnt   = q.shape.hold - LEN_W'(1);
                end else d.cnt = q.cnt - LEN_W'(1);
            end
            PH_HOLD: begin
                if (cnt_end) d.phase = PH_DONE;
                else d.cnt = q.cnt - LEN_W'(1);
            end
            PH_DONE:  d.phase = PH_IDLE;
            default:  d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, shape: '0, we: 1'b0,
                   addr: '0, wdata: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ext_active = (q.phase == PH_ALE) || (q.phase == PH_SETUP) ||
                     (q.phase == PH_STROBE) || (q.phase == PH_HOLD);
        done       = (q.phase == PH_DONE);
        rdata      = q.rdata;
        sram_en    = (q.phase == PH_INT);
        sram_we    = (q.phase == PH_INT) && q.we;
        sram_addr  = q.addr[SRAM_AW-1:0];
        sram_wdata = q.wdata;
        ale        = (q.phase == PH_ALE);
        rd_n       = !((q.phase == PH_STROBE) && !q.we);
        wr_n       = !((q.phase == PH_STROBE) && q.we);
        ad_oe      = (q.phase == PH_ALE) || (ext_active && q.we);
        ad_out     = (q.phase == PH_ALE) ? q.addr[DW-1:0] :
                     (q.we ? q.wdata : DW'(0));
        ad_hi      = ext_active ? q.addr[AW-1:DW] : HI_W'(0);
    end

    // R7: port released whenever the read strobe is active
    assert_read_port_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R12: strobes never overlap each other or the latch pulse
    assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);
    assert_ale_without_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: on-chip clock leaves external bus idle
    assert_sram_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> (!ale && rd_n && wr_n && !ad_oe));

    // R11: latch phase can only be entered from idle
    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != PH_IDLE && q.phase != PH_ALE) |=> (q.phase != PH_ALE));

    // R3: done follows the hold phase or the on-chip clock
    assert_done_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(q.phase) == PH_HOLD || $past(q.phase) == PH_INT));
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int SRAM_AW   = 10,
    parameter int CPM       = 4,
    parameter int LONG_BIAS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [2:0]         stretch,
    output logic               done,
    output logic [DW-1:0]      rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DW-1:0]      sram_wdata,
    input  logic [DW-1:0]      sram_rdata,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    input  logic [DW-1:0]      ad_in,
    output logic [AW-DW-1:0]   ad_hi,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n
);
    logic               start_int;
    logic [SRAM_AW-1:0] req_local;
    shape_t             shape_w;

    xmem_route #(.AW(AW), .SRAM_AW(SRAM_AW)) u_route (
        .addr       (addr),
        .is_int     (start_int),
        .local_addr (req_local)
    );

    xmem_stretch_map #(.CPM(CPM), .LONG_BIAS(LONG_BIAS)) u_map (
        .code  (stretch),
        .shape (shape_w)
    );

    xmem_seq #(.AW(AW), .DW(DW), .SRAM_AW(SRAM_AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .we         (we),
        .addr       ({addr[AW-1:SRAM_AW], req_local}),
        .wdata      (wdata),
        .start_int  (start_int),
        .shape_in   (shape_w),
        .done       (done),
        .rdata      (rdata),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ad_in      (ad_in),
        .ad_hi      (ad_hi),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n)
    );
endmodule

// File: tb/sim_xmem_bus_ctrl.sv
module sim_xmem_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [2:0]  stretch = '0;
    logic        done, sram_en, sram_we, ad_oe, ale, rd_n, wr_n;
    logic [7:0]  rdata, sram_wdata, sram_rdata, ad_out, ad_in, ad_hi;
    logic [9:0]  sram_addr;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xmem_bus_ctrl u0 (.*);

    // on-chip SRAM model
    logic [7:0] sram_mem [1024];
    assign sram_rdata = sram_mem[sram_addr];
    always @(posedge clk) if (sram_en && sram_we) sram_mem[sram_addr] <= sram_wdata;

    // external device model: drives the port only while read strobe is low
    logic [7:0] ext_mem [int];
    logic [15:0] lat_addr = '0;
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] ext_get(input logic [15:0] a);
        if (ext_mem.exists(int'(a))) return ext_mem[int'(a)];
        return pat(a);
    endfunction
    always @(posedge clk) begin
        if (ale) lat_addr <= {ad_hi, ad_out};
        if (!wr_n) ext_mem[int'(lat_addr)] = ad_out;
    end
    always_comb ad_in = !rd_n ? ext_get(lat_addr) : 8'h00;

    logic [7:0] ref_mem [int];

    function automatic logic [7:0] ref_get(input logic [15:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        if (a < 16'h0400) return pat(~a);
        return pat(a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference: phase lengths from the requirements
    task automatic lens(input logic [2:0] c, output int la, output int ls, output int lb, output int lh);
        int s;
        s = (c >= 3'd4) ? int'(c) + 3 : int'(c);
        la = 1; ls = 1; lb = 1; lh = 1;
        if (c == 3'd1) begin ls = 2; lh = 2; end
        else if (c == 3'd2 || c == 3'd3) lb = 1 + 4 * s;
        else if (c >= 3'd4) begin la = 5; ls = 5; lh = 5; lb = 1 + 4 * (s - 3); end
    endtask

    task automatic run(input bit w, input logic [15:0] a, input logic [7:0] wd,
                       input logic [2:0] c, input bit disturb, input string tag);
        int la, ls, lb, lh, t;
        bit internal;
        logic [7:0] exp_rd;
        internal = (a < 16'h0400);
        lens(c, la, ls, lb, lh);
        t = internal ? 1 : la + ls + lb + lh;
        exp_rd = ref_get(a);
        @(negedge clk);
        start = 1'b1; we = w; addr = a; wdata = wd; stretch = c;
        @(posedge clk);
        for (int j = 1; j <= t + 2; j++) begin
            logic [5:0] e_v, a_v;
            bit e_ale, e_rd, e_wr, e_oe, e_sr, e_dn;
            @(negedge clk);
            if (j == 1) begin
                if (disturb) begin
                    we = ~w; addr = a ^ 16'h1234; wdata = ~wd; stretch = ~c;
                end else start = 1'b0;
            end
            if (j == t + 2) start = 1'b0;
            e_ale = 0; e_rd = 1; e_wr = 1; e_oe = 0; e_sr = 0; e_dn = (j == t + 1);
            if (internal) e_sr = (j == 1);
            else if (j <= la) begin e_ale = 1; e_oe = 1; end
            else if (j <= la + ls) e_oe = w;
            else if (j <= la + ls + lb) begin e_oe = w; e_rd = w; e_wr = !w; end
            else if (j <= t) e_oe = w;
            e_v = {e_ale, e_rd, e_wr, e_oe, e_sr, e_dn};
            a_v = {ale, rd_n, wr_n, ad_oe, sram_en, done};
            check(a_v === e_v, $sformatf("R3 R4 R5 R6 R11 shape %s j=%0d", tag, j), a_v, e_v);
            if (!internal && j <= t) begin
                check(ad_hi === a[15:8], $sformatf("R9 hi addr %s", tag), ad_hi, a[15:8]);
                if (j <= la)
                    check(ad_out === a[7:0], $sformatf("R8 low addr %s", tag), ad_out, a[7:0]);
                else if (w)
                    check(ad_out === wd, $sformatf("R8 write data %s", tag), ad_out, wd);
            end
            if (internal && j == 1) begin
                check(sram_addr === a[9:0] && sram_we === w,
                      $sformatf("R2 sram addr %s", tag), {sram_we, sram_addr}, {w, a[9:0]});
            end
            if (j == t + 1 && !w)
                check(rdata === exp_rd, $sformatf("R7 read data %s", tag), rdata, exp_rd);
            if (j == t + 2)
                check(ad_hi === 8'h00 && !done, $sformatf("R1 R9 idle after %s", tag), ad_hi, 0);
        end
        if (w) ref_mem[int'(a)] = wd;
    endtask

    // contention monitor
    always @(negedge clk) if (rst_n && !rd_n) check(!ad_oe, "R7 contention", ad_oe, 0);

    initial begin
        for (int i = 0; i < 1024; i++) sram_mem[i] = pat(~16'(i));
        repeat (3) @(negedge clk);
        check({ale, rd_n, wr_n, ad_oe, sram_en, done} === 6'b011000, "R1 reset state",
              {ale, rd_n, wr_n, ad_oe, sram_en, done}, 6'b011000);
        rst_n = 1'b1;
        @(negedge clk);
        check({ale, rd_n, wr_n, ad_oe, sram_en, done} === 6'b011000, "R1 idle after reset",
              {ale, rd_n, wr_n, ad_oe, sram_en, done}, 6'b011000);
        for (int c = 0; c < 8; c++) begin
            logic [15:0] a;
            a = 16'h0400 + 16'(c * 16'h0111);
            run(1'b1, a, 8'hA0 + 8'(c), 3'(c), 1'b0, $sformatf("R8 write code%0d", c));
            run(1'b0, a, 8'h00, 3'(c), 1'b0, $sformatf("R7 read code%0d", c));
        end
        run(1'b0, 16'h0400, 8'h00, 3'd0, 1'b0, "R2 boundary 0400 ext");
        run(1'b0, 16'h03FF, 8'h00, 3'd7, 1'b0, "R2 boundary 03FF int");
        run(1'b1, 16'h0000, 8'h3C, 3'd2, 1'b0, "R2 int write 0000");
        run(1'b0, 16'h0000, 8'h00, 3'd2, 1'b0, "R2 int read 0000");
        run(1'b0, 16'hFFFF, 8'h00, 3'd5, 1'b1, "R10 R11 stretch change and restart");
        run(1'b1, 16'h8001, 8'h99, 3'd1, 1'b1, "R10 R11 write disturbed");
        run(1'b0, 16'h8001, 8'h00, 3'd4, 1'b0, "R8 readback");
        run(1'b0, 16'h0123, 8'h00, 3'd3, 1'b1, "R11 int disturbed");
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule